// File: doc/BRIEF.md
# Interleaved Fetch Program-Counter Sequencer

This block produces the fetch address and an instruction-valid qualifier for a small 32-bit core that issues one instruction every third clock. The instruction in flight needs three cycles before its branch outcome is known. So the sequencer runs a three-slot rotation. A single valid token circulates through a three-stage history. The address for each valid slot is built from the redirect decision, the branch target and the incremented address of the slot three cycles earlier. A slot that is not valid is never allowed to redirect, and it does not move the address that the next valid slot sees.

A two-state controller tracks reset. In state `SEQ_HELD` the sequencer is in reset or has just come out of it. In state `SEQ_RUN` it is running. The transition `SEQ_HELD -> SEQ_RUN` happens on the first clock with reset low. Every reset cycle forces `SEQ_RUN -> SEQ_HELD`. A one-cycle start pulse is raised while the controller is in `SEQ_HELD` and reset is low. That pulse injects the valid token into the rotation. The execute logic outside the block supplies the taken flag and the target for the instruction that is in its valid slot.

Top module: `fseq_pc_core`

## Requirements
- R1: In the cycle after any cycle with `rst` high, `fetch_pc` is zero. This covers every cycle of a reset held for several cycles, except the first one, and it covers the first cycle after release.
- R2: `start` is low while `rst` is high. It is high for exactly one cycle: the first cycle with `rst` low after a reset. After that it stays low until the next reset.
- R3: `fetch_valid` is low while `rst` is high and high in the start cycle. After that it is high in exactly every third cycle (start+3, start+6, ...) and low in all other cycles.
- R4: `br_taken` and `br_target` are ignored in a cycle where `fetch_valid` is low. The address of the next valid slot is still the previous valid address plus 4.
- R5: If `br_taken` is high in a valid cycle, `fetch_pc` three cycles later equals `br_target` with bits [1:0] forced to zero.
- R6: If `br_taken` is low in a valid cycle, `fetch_pc` three cycles later equals that cycle's `fetch_pc` plus 4.
- R7: Bits [1:0] of `fetch_pc` are always zero. The low two bits of `br_target` have no effect on any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_taken | input | 1 | Branch-taken decision for the instruction in the current slot |
| br_target | input | 32 | Branch destination byte address for the current slot |
| fetch_pc | output | 32 | Fetch address for the current slot |
| fetch_valid | output | 1 | High when the current slot carries a real instruction |
| start | output | 1 | One-cycle pulse on the first cycle out of reset |

## Verification
Suppose the valid history were corrupted, for example a lost or duplicated token. Within three cycles the port would show a valid bit outside the one-in-three pattern, or no valid bit at all. Suppose a wrong entry sat in the redirect, target or increment delay line. The address of the very next valid slot would then differ from a model that adds 4 or loads the aligned target. That slot is at most three cycles later. Branch flags driven in invalid slots with distinctive targets would show any leak of unqualified redirects at the next valid slot.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    // Reset-tracking controller states
    typedef enum logic {
        SEQ_HELD = 1'b0,   // in reset, or first cycle after it
        SEQ_RUN  = 1'b1    // running
    } seq_state_e;

endpackage

// File: rtl/fseq_start_ctl.sv
module fseq_start_ctl
    import fseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic start
);

    seq_state_e state_q;
    seq_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HELD: if (!rst) state_d = SEQ_RUN;
            SEQ_RUN:  if (rst)  state_d = SEQ_HELD;
            default:            state_d = SEQ_HELD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_HELD;
        else     state_q <= state_d;
    end

    // output logic
    always_comb begin
        start = 1'b0;
        unique case (state_q)
            SEQ_HELD: start = !rst;
            SEQ_RUN:  start = 1'b0;
            default:  start = 1'b0;
        endcase
    end

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R2
    start_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> start);

endmodule

// File: rtl/fseq_delay_line.sv
module fseq_delay_line #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/fseq_pc_core.sv
module fseq_pc_core #(
    parameter int XLEN        = 32,
    parameter int ISSUE_GAP   = 3,
    parameter int INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] fetch_pc,
    output logic            fetch_valid,
    output logic            start
);

    localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'(INSTR_BYTES - 1);
    localparam logic [XLEN-1:0] PC_STEP    = XLEN'(INSTR_BYTES);
    localparam int              SLOT_W     = 1 + 2 * XLEN;

    logic            start_w;
    logic            valid_now;
    logic            valid_tap;
    logic            redirect_now;
    logic [XLEN-1:0] tgt_aligned;
    logic [XLEN-1:0] pc_now;
    logic [XLEN-1:0] pc_inc;
    logic            rst_d1;
    logic [SLOT_W-1:0] slot_in;
    logic [SLOT_W-1:0] slot_tap;
    logic            redirect_tap;
    logic [XLEN-1:0] tgt_tap;
    logic [XLEN-1:0] inc_tap;

    fseq_start_ctl u_start (
        .clk   (clk),
        .rst   (rst),
        .start (start_w)
    );

    // valid token recirculates through a history as deep as the issue gap
    always_comb begin
        if (rst)          valid_now = 1'b0;
        else if (start_w) valid_now = 1'b1;
        else              valid_now = valid_tap;
    end

    fseq_delay_line #(.WIDTH(1), .DEPTH(ISSUE_GAP)) u_valid_hist (
        .clk  (clk),
        .rst  (rst),
        .din  (valid_now),
        .dout (valid_tap)
    );

    // redirect qualified by the slot's validity
    assign redirect_now = valid_now & br_taken;
    assign tgt_aligned  = br_target & ~ALIGN_MASK;
    assign pc_inc       = pc_now + PC_STEP;
    assign slot_in      = {redirect_now, tgt_aligned, pc_inc};

    fseq_delay_line #(.WIDTH(SLOT_W), .DEPTH(ISSUE_GAP)) u_slot_hist (
        .clk  (clk),
        .rst  (rst),
        .din  (slot_in),
        .dout (slot_tap)
    );

    assign redirect_tap = slot_tap[SLOT_W-1];
    assign tgt_tap      = slot_tap[2*XLEN-1:XLEN];
    assign inc_tap      = slot_tap[XLEN-1:0];

    always_ff @(posedge clk) begin
        rst_d1 <= rst;
    end

    always_comb begin
        if (rst_d1)            pc_now = '0;
        else if (redirect_tap) pc_now = tgt_tap;
        else                   pc_now = inc_tap;
    end

    assign fetch_pc    = pc_now;
    assign fetch_valid = valid_now;
    assign start       = start_w;

    // R1
    pc_zero_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_pc == '0));

    // R7
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_pc & ALIGN_MASK) == '0);

    if (ISSUE_GAP == 3) begin : g_gap3_chk
        // R3
        valid_period_chk: assert property (@(posedge clk) disable iff (rst)
            fetch_valid |=> !fetch_valid ##1 !fetch_valid ##1 fetch_valid);

        // R5
        taken_redirect_chk: assert property (@(posedge clk) disable iff (rst)
            (fetch_valid && br_taken) |=> ##2
            (fetch_pc == ($past(br_target, 3) & ~ALIGN_MASK)));

        // R6
        not_taken_step_chk: assert property (@(posedge clk) disable iff (rst)
            (fetch_valid && !br_taken) |=> ##2
            (fetch_pc == $past(fetch_pc, 3) + PC_STEP));
    end

endmodule

// File: tb/test_fseq_pc_core.sv
`timescale 1ns/1ps
module test_fseq_pc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic [31:0] fetch_pc;
    logic        fetch_valid;
    logic        start;

    int n_checks = 0;
    int n_fail   = 0;
    int phase    = 0;
    logic        first_cycle = 1'b0;
    logic [31:0] exp_pc = '0;
    logic [31:0] lfsr = 32'h1234_5679;

    always #2.5 clk = ~clk;

    fseq_pc_core i_fseq_pc_core (
        .clk         (clk),
        .rst         (rst),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .fetch_pc    (fetch_pc),
        .fetch_valid (fetch_valid),
        .start       (start)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // hold reset for n cycles; R1, R2, R3 during reset
    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = 1'b1; br_taken = 1'b0; br_target = '0;
            #1;
            check(start == 1'b0, "R2", "start in reset", 32'(start), 32'd0);
            check(fetch_valid == 1'b0, "R3", "valid in reset", 32'(fetch_valid), 32'd0);
            if (i > 0)
                check(fetch_pc == 32'd0, "R1", "pc in held reset", fetch_pc, 32'd0);
        end
        phase = 0; exp_pc = '0; first_cycle = 1'b1;
    endtask

    // one running cycle with reference model
    task automatic cyc(input logic tk, input logic [31:0] tg, input string req);
        logic exp_v;
        @(negedge clk);
        rst = 1'b0; br_taken = tk; br_target = tg;
        #1;
        exp_v = (phase == 0);
        check(fetch_valid == exp_v, "R3", "valid pattern", 32'(fetch_valid), 32'(exp_v));
        check(start == first_cycle, "R2", "start pulse", 32'(start), 32'(first_cycle));
        check(fetch_pc[1:0] == 2'b00, "R7", "pc alignment", fetch_pc, fetch_pc & ~32'd3);
        if (exp_v) begin
            check(fetch_pc == exp_pc, first_cycle ? "R1" : req, "valid-slot pc", fetch_pc, exp_pc);
            exp_pc = tk ? (tg & ~32'd3) : exp_pc + 32'd4;
        end
        first_cycle = 1'b0;
        phase = (phase + 1) % 3;
    endtask

    task automatic test_reset_release;
        do_reset(3);
        for (int i = 0; i < 6; i++) cyc(1'b0, '0, "R6");
    endtask

    task automatic test_sequential;
        do_reset(2);
        for (int i = 0; i < 30; i++) cyc(1'b0, '0, "R6");
    endtask

    task automatic test_taken;
        do_reset(2);
        cyc(1'b1, 32'h0000_0100, "R5");
        cyc(1'b0, '0, "R5"); cyc(1'b0, '0, "R5");
        cyc(1'b0, '0, "R5");        // expects 0x100
        cyc(1'b0, '0, "R6"); cyc(1'b0, '0, "R6");
        cyc(1'b1, 32'h8000_0040, "R6"); // expects 0x104, redirects
        cyc(1'b0, '0, "R5"); cyc(1'b0, '0, "R5");
        for (int i = 0; i < 6; i++) cyc(1'b0, '0, "R5");
    endtask

    task automatic test_invalid_branch;
        do_reset(2);
        for (int i = 0; i < 12; i++)
            cyc(phase != 0, 32'hDEAD_BEE0 + 32'(i * 16), "R4");
    endtask

    task automatic test_misaligned;
        do_reset(2);
        cyc(1'b1, 32'h0000_0203, "R7");
        cyc(1'b1, 32'h0000_0555, "R7"); cyc(1'b1, 32'h0000_0777, "R7");
        cyc(1'b1, 32'h0000_0FF1, "R7");  // expects 0x200
        cyc(1'b0, '0, "R7"); cyc(1'b0, '0, "R7");
        cyc(1'b0, '0, "R7");              // expects 0xFF0
        cyc(1'b0, '0, "R7"); cyc(1'b0, '0, "R7");
        cyc(1'b0, '0, "R6");
    endtask

    task automatic test_midrun_reset;
        do_reset(2);
        for (int i = 0; i < 7; i++) cyc(1'b1, 32'h0000_4000, "R5");
        do_reset(1);
        for (int i = 0; i < 9; i++) cyc(1'b0, '0, "R1");
    endtask

    task automatic test_random;
        do_reset(2);
        for (int i = 0; i < 600; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            cyc(lfsr[3:0] < 4'd5, lfsr, (phase == 0) ? "R5" : "R4");
        end
    endtask

    initial begin
        test_reset_release();
        test_sequential();
        test_taken();
        test_invalid_branch();
        test_misaligned();
        test_midrun_reset();
        test_random();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule